// File: doc/BRIEF.md
# Banked Interrupt Group Register File

This block holds the group assignment of every interrupt line in an interrupt distributor. Each line belongs either to group 0, the secure group, or to group 1, the non-secure group. Software reaches the bits through a byte-wide request port. Each request carries a byte offset, a secure-access attribute and the index of the requesting CPU. Each byte in the group window covers eight consecutive interrupts.

Interrupts numbered below 32 are private to each CPU. They keep one group bit per CPU, and an access always works on the copy that belongs to the requester. Interrupts from 32 upward keep one shared bit that every CPU sees.

Configuration inputs decide whether groups exist at all, whether the security extensions restrict access, and how many interrupts are implemented. The complete per-CPU view of every group bit is driven out continuously for the priority logic downstream.

Top module: `irq_group_bank`

## Requirements
- R1: The group window covers byte offsets 0x80 to 0xFF. Bit i of the byte at offset 0x80+k stands for interrupt 8*k+i.
- R2: A write that is accepted puts interrupt n in group 1 when its data bit is 1 and in group 0 when its data bit is 0. The new value appears on `grp_bits` in the cycle after the edge that samples the write.
- R3: Groups exist only when `cfg_revision` equals 2 or `cfg_sec_ext` is 1. Without groups, a window read returns 0 with no error and a window write changes nothing.
- R4: When `cfg_sec_ext` is 1, a request with `req_secure` at 0 reads 0, raises no error, and its write is discarded.
- R5: An access is a bad-register access when it passes the R3 and R4 gating and the first interrupt of its byte (8*k) is at or above `cfg_num_irq` or at or above `NUM_IRQ`. Such an access returns `rsp_err` 1 and read data 0, and it changes no group bit.
- R6: A write to interrupts 0 to 31 updates only the copy of the CPU given by `req_cpu`.
- R7: A write to interrupts 32 and above updates the one shared bit, which all CPUs see.
- R8: A read returns, for each bit, the group bit as seen by `req_cpu`. For interrupts 0 to 31 this is that CPU's own copy.
- R9: After reset every group bit of every CPU is 0, and `rsp_valid` is 0.
- R10: Every request gives exactly one `rsp_valid` pulse one cycle later. No request means no `rsp_valid` and no `rsp_err`. A write response carries read data 0.
- R11: A request whose offset lies outside the window changes nothing and returns data 0 with no error.
- R12: `grp_bits` bit c*NUM_IRQ+n is the group bit of interrupt n as seen by CPU c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_offset | input | ADDR_W | Distributor byte offset |
| req_secure | input | 1 | Secure-access attribute of the request |
| req_cpu | input | CPU_W | Index of the requesting CPU |
| req_wdata | input | 8 | Write data byte |
| cfg_revision | input | 2 | Architecture revision; value 2 enables groups |
| cfg_sec_ext | input | 1 | Security extensions present |
| cfg_num_irq | input | 11 | Number of implemented interrupts |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 8 | Read data byte |
| rsp_err | output | 1 | Bad-register access flag |
| grp_bits | output | NUM_CPU*NUM_IRQ | Group bit of every interrupt for every CPU |

## Verification
The response to a request sampled at a rising edge is registered at that edge. A write becomes visible on `grp_bits` at that same edge. Both results are therefore due one cycle after the request.

The bench drives each request on a falling edge, so it is sampled at the next rising edge. It drops the strobe and compares response and group vector on the falling edge after that, halfway between edges.

The expected data come from a bench model of the per-CPU private bits and the shared bits. The bench updates this model only for accesses that the gating and bad-register rules accept.

// File: rtl/grp_pkg.sv
package grp_pkg;

    localparam int unsigned PRIV_LINES = 32;
    localparam int unsigned NUM_W      = 11;

    typedef struct packed {
        logic       in_win;
        logic       open;
        logic       bad;
        logic [6:0] byte_idx;
    } grp_acc_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] rdata;
        logic       err;
    } grp_rsp_t;

endpackage

// File: rtl/grp_access_gate.sv
module grp_access_gate
    import grp_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 256,
    parameter int unsigned ADDR_W  = 12
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic              secure,
    input  logic [1:0]        revision,
    input  logic              sec_ext,
    input  logic [NUM_W-1:0]  num_irq,
    output grp_acc_t          acc
);
    localparam logic [NUM_W-1:0] IRQ_LIM = NUM_W'(NUM_IRQ);

    logic             has_groups;
    logic [NUM_W-1:0] first_irq;

    always_comb begin
        has_groups   = (revision == 2'd2) || sec_ext;
        first_irq    = {1'b0, offset[6:0], 3'b000};
        acc.in_win   = (offset[ADDR_W-1:7] == (ADDR_W-7)'(1));
        acc.byte_idx = offset[6:0];
        acc.open     = has_groups && !(sec_ext && !secure);
        acc.bad      = acc.open && ((first_irq >= num_irq) || (first_irq >= IRQ_LIM));
    end

endmodule

// File: rtl/grp_bit_store.sv
module grp_bit_store
    import grp_pkg::*;
#(
    parameter int unsigned NUM_CPU = 8,
    parameter int unsigned NUM_IRQ = 256,
    parameter int unsigned CPU_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [6:0]                 byte_idx,
    input  logic [CPU_W-1:0]           cpu,
    input  logic [7:0]                 wdata,
    output logic [7:0]                 rd_data,
    output logic [NUM_CPU*NUM_IRQ-1:0] grp_bits
);
    localparam int unsigned NUM_SHR = NUM_IRQ - PRIV_LINES;
    localparam int unsigned SHR_W   = $clog2(NUM_SHR);

    typedef struct packed {
        logic [NUM_SHR-1:0]                    shr;
        logic [NUM_CPU-1:0][PRIV_LINES-1:0]    priv;
    } store_t;

    store_t     st_d, st_q;
    logic [9:0] wr_irq, rd_irq, wr_sidx, rd_sidx;

    always_comb begin
        st_d    = st_q;
        rd_data = '0;
        wr_irq  = '0;
        rd_irq  = '0;
        wr_sidx = '0;
        rd_sidx = '0;
        for (int i = 0; i < 8; i++) begin
            wr_irq  = {byte_idx, i[2:0]};
            wr_sidx = wr_irq - 10'd32;
            if (wr_en) begin
                if (wr_irq < 10'd32) begin
                    st_d.priv[cpu][wr_irq[4:0]] = wdata[i];
                end else if (wr_irq < 10'(NUM_IRQ)) begin
                    st_d.shr[wr_sidx[SHR_W-1:0]] = wdata[i];
                end
            end
            rd_irq  = {byte_idx, i[2:0]};
            rd_sidx = rd_irq - 10'd32;
            if (rd_irq < 10'd32) begin
                rd_data[i] = st_q.priv[cpu][rd_irq[4:0]];
            end else if (rd_irq < 10'(NUM_IRQ)) begin
                rd_data[i] = st_q.shr[rd_sidx[SHR_W-1:0]];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_view
        assign grp_bits[c*NUM_IRQ +: NUM_IRQ] = {st_q.shr, st_q.priv[c]};

        // R6
        bank_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (byte_idx < 7'd4) && (cpu != CPU_W'(c))) |=> $stable(st_q.priv[c]))
            else $error("private copy of another CPU changed");
    end

    // R5
    store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q))
        else $error("group bits changed without an accepted write");

    // R7
    shr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (byte_idx < 7'd4)) |=> $stable(st_q.shr))
        else $error("shared bits changed by a private-range write");

endmodule

// File: rtl/irq_group_bank.sv
module irq_group_bank
    import grp_pkg::*;
#(
    parameter int unsigned NUM_CPU = 8,
    parameter int unsigned NUM_IRQ = 256,
    parameter int unsigned ADDR_W  = 12,
    localparam int unsigned CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_offset,
    input  logic                       req_secure,
    input  logic [CPU_W-1:0]           req_cpu,
    input  logic [7:0]                 req_wdata,
    input  logic [1:0]                 cfg_revision,
    input  logic                       cfg_sec_ext,
    input  logic [10:0]                cfg_num_irq,
    output logic                       rsp_valid,
    output logic [7:0]                 rsp_rdata,
    output logic                       rsp_err,
    output logic [NUM_CPU*NUM_IRQ-1:0] grp_bits
);
    grp_acc_t   acc;
    grp_rsp_t   rsp_d, rsp_q;
    logic       hit, wr_en;
    logic [7:0] rd_data;

    grp_access_gate #(
        .NUM_IRQ (NUM_IRQ),
        .ADDR_W  (ADDR_W)
    ) i_gate (
        .offset   (req_offset),
        .secure   (req_secure),
        .revision (cfg_revision),
        .sec_ext  (cfg_sec_ext),
        .num_irq  (cfg_num_irq),
        .acc      (acc)
    );

    grp_bit_store #(
        .NUM_CPU (NUM_CPU),
        .NUM_IRQ (NUM_IRQ),
        .CPU_W   (CPU_W)
    ) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .byte_idx (acc.byte_idx),
        .cpu      (req_cpu),
        .wdata    (req_wdata),
        .rd_data  (rd_data),
        .grp_bits (grp_bits)
    );

    always_comb begin
        hit         = req_valid && acc.in_win && acc.open && !acc.bad;
        wr_en       = hit && req_write;
        rsp_d.valid = req_valid;
        rsp_d.err   = req_valid && acc.in_win && acc.bad;
        rsp_d.rdata = (hit && !req_write) ? rd_data : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.rdata;
    assign rsp_err   = rsp_q.err;

    // R10
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid)
        else $error("request without response");

    // R10
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_err && rsp_rdata == 8'h00))
        else $error("response without request");

    // R4
    ns_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_sec_ext && !req_secure) |=> (!rsp_err && rsp_rdata == 8'h00))
        else $error("non-secure access not masked");

    // R3
    no_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_revision != 2'd2 && !cfg_sec_ext) |=> (!rsp_err && rsp_rdata == 8'h00))
        else $error("access without groups not masked");

    // R11
    out_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_offset[ADDR_W-1:7] != (ADDR_W-7)'(1)) |=> ($stable(grp_bits) && !rsp_err && rsp_rdata == 8'h00))
        else $error("access outside window had an effect");

endmodule

// File: tb/test_irq_group_bank.sv
module test_irq_group_bank;
    localparam int NC = 2;
    localparam int NI = 64;
    localparam int GW = NC * NI;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [11:0]   req_offset = '0;
    logic          req_secure = 1'b0;
    logic [0:0]    req_cpu = '0;
    logic [7:0]    req_wdata = '0;
    logic [1:0]    cfg_revision = 2'd2;
    logic          cfg_sec_ext = 1'b0;
    logic [10:0]   cfg_num_irq = 11'd64;
    logic          rsp_valid;
    logic [7:0]    rsp_rdata;
    logic          rsp_err;
    logic [GW-1:0] grp_bits;

    int checks = 0;
    int errors = 0;

    bit mp [NC][32];
    bit ms [NI];

    always #10 clk = ~clk;

    irq_group_bank #(.NUM_CPU(NC), .NUM_IRQ(NI), .ADDR_W(12)) i_irq_group_bank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_secure(req_secure), .req_cpu(req_cpu),
        .req_wdata(req_wdata), .cfg_revision(cfg_revision), .cfg_sec_ext(cfg_sec_ext),
        .cfg_num_irq(cfg_num_irq), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .grp_bits(grp_bits)
    );

    task automatic chk(input string tag, input logic [GW-1:0] act, input logic [GW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit mbit(input int cpu, input int irq);
        if (irq < 32) return mp[cpu][irq];
        if (irq < NI) return ms[irq];
        return 1'b0;
    endfunction

    function automatic logic [GW-1:0] mflat();
        logic [GW-1:0] v = '0;
        for (int c = 0; c < NC; c++)
            for (int n = 0; n < NI; n++) v[c*NI+n] = mbit(c, n);
        return v;
    endfunction

    task automatic do_req(input bit w, input int off, input bit sec, input int cpu, input int wd);
        logic [7:0] erd = '0;
        bit inw, opn, bad, hit;
        int base, lim;
        string tag;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_offset = 12'(off);
        req_secure = sec; req_cpu = 1'(cpu); req_wdata = 8'(wd);
        inw  = (off >= 128) && (off < 256);
        opn  = ((cfg_revision == 2'd2) || cfg_sec_ext) && !(cfg_sec_ext && !sec);
        base = (off - 128) * 8;
        lim  = (int'(cfg_num_irq) < NI) ? int'(cfg_num_irq) : NI;
        bad  = inw && opn && (base >= lim);
        hit  = inw && opn && !bad;
        if (!inw) tag = "R11";
        else if (!opn) tag = (cfg_sec_ext && !sec) ? "R4" : "R3";
        else if (bad) tag = "R5";
        else if (w) tag = (base < 32) ? "R2 R6 R12" : "R2 R7 R12";
        else tag = "R1 R8";
        if (!w && hit)
            for (int i = 0; i < 8; i++) erd[i] = mbit(cpu, base + i);
        if (w && hit)
            for (int i = 0; i < 8; i++) begin
                if (base + i < 32) mp[cpu][base+i] = wd[i];
                else if (base + i < NI) ms[base+i] = wd[i];
            end
        @(negedge clk);
        req_valid = 1'b0;
        chk({"R10 valid ", tag}, GW'(rsp_valid), GW'(1));
        chk({"err ", tag}, GW'(rsp_err), GW'(bad));
        chk({"rdata ", tag}, GW'(rsp_rdata), GW'(erd));
        chk({"grp_bits ", tag}, grp_bits, mflat());
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset grp_bits", grp_bits, '0);
        chk("R9 reset valid", GW'(rsp_valid), '0);
        // groups via revision 2, no security gate
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < 8; k++) do_req(1, 128 + k, 0, c, (k * 37 + c * 91 + 5) & 255);
        for (int c = 0; c < NC; c++)
            for (int k = 0; k < 8; k++) do_req(0, 128 + k, 0, c, 0);
        do_req(1, 128, 0, 1, 255);
        do_req(1, 131, 0, 0, 0);
        do_req(1, 132, 0, 1, 255);
        do_req(0, 132, 0, 0, 0);
        do_req(0, 128, 0, 0, 0);
        do_req(0, 128, 0, 1, 0);
        @(negedge clk);
        chk("R10 idle", GW'(rsp_valid), '0);
        // bad register range
        cfg_num_irq = 11'd40;
        for (int k = 0; k < 16; k++) do_req(1, 128 + k, 0, 0, 165);
        for (int k = 0; k < 16; k++) do_req(0, 128 + k, 0, 1, 0);
        cfg_num_irq = 11'd64;
        // no groups
        cfg_revision = 2'd1;
        do_req(1, 128, 1, 0, 90);
        do_req(1, 133, 1, 1, 90);
        do_req(0, 133, 1, 1, 0);
        do_req(0, 140, 1, 0, 0);
        // security extensions
        cfg_sec_ext = 1'b1;
        do_req(1, 129, 0, 0, 60);
        do_req(0, 129, 0, 0, 0);
        do_req(0, 140, 0, 0, 0);
        do_req(1, 129, 1, 0, 60);
        do_req(1, 134, 1, 1, 195);
        do_req(0, 129, 1, 0, 0);
        do_req(0, 134, 1, 0, 0);
        // outside the window
        do_req(1, 0, 1, 0, 255);
        do_req(1, 127, 1, 1, 255);
        do_req(1, 256, 1, 0, 255);
        do_req(0, 300, 1, 0, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule